// File: doc/BRIEF.md
# External Interrupt Pin Detector

This block watches one external interrupt pin that is asynchronous to the system clock. It synchronizes the pin, finds the transition from the idle level to the active level, and records it in a sticky status flag. The flag drives an interrupt request whenever the interrupt enable is set. The active level is programmable: either low, where falling transitions count, or high, where rising transitions count.

Two detection modes exist. In edge mode a write-one acknowledge clears the flag at once, even while the pin is still active. In edge-plus-level mode the flag is set by the transition and then cannot be cleared as long as the synchronized pin stays active, so software reading the flag also sees the live pin state. The block also reports which internal pull device the pad would use. That report is a pair of outputs and is not modelled electrically.

Top module: `ext_pin_irq`

## Requirements
- R1: After reset, `flag` and `irq` are 0.
- R2: When `cfg_enable`=1, a change of `pin_async` from the idle level to the active level sets `flag` on the third rising clock edge after the change, and not before. The active level is 1 when `cfg_high_active`=1 and 0 when `cfg_high_active`=0.
- R3: A change from the active level back to the idle level never sets `flag`.
- R4: With `cfg_level_mode`=0, an `ack_wr` pulse clears `flag` on the next clock edge even while the pin stays active. `flag` then stays 0 until a new idle-to-active transition occurs.
- R5: With `cfg_level_mode`=1, `ack_wr` has no effect while the synchronized pin is active. Once the pin has returned to idle (three clock edges), `ack_wr` clears `flag`.
- R6: If `ack_wr` and a newly detected transition fall on the same clock edge, `flag` is 1 after that edge.
- R7: `irq` is 1 exactly when `flag`=1 and `cfg_irq_en`=1.
- R8: While `cfg_enable`=0, `flag` is 0 from the next clock edge on, `irq` is 0, and pin transitions are not recorded.
- R9: `pull_en` = `cfg_enable` AND NOT `cfg_pull_off`. `pull_up` = NOT `cfg_high_active`, so the pad pulls up for a low-active pin and pulls down for a high-active pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_async | input | 1 | Raw external interrupt pin |
| cfg_enable | input | 1 | Block enable |
| cfg_high_active | input | 1 | 1: high level and rising transition are active; 0: low level and falling transition |
| cfg_level_mode | input | 1 | 0: edge only; 1: edge plus level hold |
| cfg_irq_en | input | 1 | Interrupt request enable |
| cfg_pull_off | input | 1 | 1 turns the internal pull device off |
| ack_wr | input | 1 | Write-one acknowledge pulse |
| flag | output | 1 | Sticky status flag |
| irq | output | 1 | Masked interrupt request |
| pull_en | output | 1 | Internal pull device is on |
| pull_up | output | 1 | Pull direction: 1 pull-up, 0 pull-down |

## Verification
The acknowledge write and a fresh idle-to-active detection can land on the same clock edge. In that case the flag must stay set. The bench first sets the flag and returns the pin to idle. It then re-asserts the pin and times the `ack_wr` pulse to the third edge after the change, so that the clear and the set meet. This is swept over both polarities, both modes and both interrupt-enable settings, and after that edge a 1 is expected on `flag` and `cfg_irq_en` is expected on `irq`.

// File: rtl/epi_pkg.sv
package epi_pkg;

   typedef struct packed {
      logic enable;
      logic high_active;
      logic level_mode;
      logic irq_en;
      logic pull_off;
   } epi_cfg_t;

   // True when a raw pin level is the active level for the chosen polarity
   function automatic logic level_is_active(input logic lvl, input logic high_active);
      return (lvl == high_active);
   endfunction

endpackage

// File: rtl/epi_sync.sv
module epi_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   localparam int LAST = STAGES - 1;

   if (STAGES < 2) begin : g_bad_depth
      $error("epi_sync: STAGES must be at least 2");
   end

   logic [LAST:0] chain;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[0] <= RST_VAL;
            else        chain[0] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[i] <= RST_VAL;
            else        chain[i] <= chain[i-1];
         end
      end
   end

   assign q = chain[LAST];
endmodule

// File: rtl/epi_edge.sv
module epi_edge #(
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl_in,
   input  logic high_active,
   output logic active_now,
   output logic hit
);
   import epi_pkg::*;

   logic lvl_prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lvl_prev <= RST_VAL;
      else        lvl_prev <= lvl_in;
   end

   assign active_now = level_is_active(lvl_in, high_active);
   assign hit        = active_now && !level_is_active(lvl_prev, high_active);
endmodule

// File: rtl/epi_flag.sv
module epi_flag (
   input  logic             clk,
   input  logic             rst_n,
   input  epi_pkg::epi_cfg_t cfg,
   input  logic             hit,
   input  logic             active_now,
   input  logic             ack,
   output logic             flag
);
   logic flag_q, flag_d, ack_blocked;

   assign ack_blocked = cfg.level_mode && active_now;

   always_comb begin
      flag_d = flag_q;
      if (!cfg.enable)          flag_d = 1'b0;
      else if (hit)             flag_d = 1'b1;
      else if (ack && !ack_blocked) flag_d = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q <= 1'b0;
      else        flag_q <= flag_d;
   end

   assign flag = flag_q;
endmodule

// File: rtl/ext_pin_irq.sv
module ext_pin_irq #(
   parameter int   SYNC_STAGES   = 2,
   parameter logic PIN_RESET_LVL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_async,
   input  logic cfg_enable,
   input  logic cfg_high_active,
   input  logic cfg_level_mode,
   input  logic cfg_irq_en,
   input  logic cfg_pull_off,
   input  logic ack_wr,
   output logic flag,
   output logic irq,
   output logic pull_en,
   output logic pull_up
);
   import epi_pkg::*;

   epi_cfg_t cfg;
   logic     pin_sync, pin_active, edge_hit;

   assign cfg = '{enable:      cfg_enable,
                  high_active: cfg_high_active,
                  level_mode:  cfg_level_mode,
                  irq_en:      cfg_irq_en,
                  pull_off:    cfg_pull_off};

   epi_sync #(.STAGES(SYNC_STAGES), .RST_VAL(PIN_RESET_LVL)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(pin_async), .q(pin_sync));

   epi_edge #(.RST_VAL(PIN_RESET_LVL)) u_edge (
      .clk(clk), .rst_n(rst_n), .lvl_in(pin_sync), .high_active(cfg.high_active),
      .active_now(pin_active), .hit(edge_hit));

   epi_flag u_flag (
      .clk(clk), .rst_n(rst_n), .cfg(cfg), .hit(edge_hit),
      .active_now(pin_active), .ack(ack_wr), .flag(flag));

   assign irq     = flag && cfg.irq_en;
   assign pull_en = cfg.enable && !cfg.pull_off;
   assign pull_up = !cfg.high_active;
endmodule

// File: rtl/epi_checker.sv
module epi_checker (
   input logic clk,
   input logic rst_n,
   input logic enable,
   input logic level_mode,
   input logic ack,
   input logic hit,
   input logic active_now,
   input logic flag,
   input logic irq
);
   assert_edge_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && hit) |=> flag);

   assert_no_spurious_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!flag && !hit) |=> !flag);

   assert_ack_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && ack && !hit && !level_mode) |=> !flag);

   assert_level_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && level_mode && active_now && flag) |=> flag);

   assert_ack_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && ack && hit) |=> flag);

   assert_irq_needs_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> flag);

   assert_disabled_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> !flag);
endmodule

bind ext_pin_irq epi_checker u_chk (
   .clk(clk), .rst_n(rst_n), .enable(cfg_enable), .level_mode(cfg_level_mode),
   .ack(ack_wr), .hit(edge_hit), .active_now(pin_active), .flag(flag), .irq(irq));

// File: tb/sim_ext_pin_irq.sv
module sim_ext_pin_irq;
   localparam time CLK_PERIOD = 10ns;

   logic clk = 1'b0, rst_n = 1'b0;
   logic pin_async = 1'b0, cfg_enable = 1'b0, cfg_high_active = 1'b0;
   logic cfg_level_mode = 1'b0, cfg_irq_en = 1'b0, cfg_pull_off = 1'b0, ack_wr = 1'b0;
   logic flag, irq, pull_en, pull_up;
   int   n_cmp = 0, n_bad = 0;
   bit   done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   ext_pin_irq u0 (.*);

   task automatic chk(input string req, input logic act, input logic exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulse_ack();
      ack_wr = 1'b1;
      cyc(1);
      ack_wr = 1'b0;
   endtask

   initial begin
      cyc(3);
      chk("R1 flag", flag, 1'b0);
      chk("R1 irq", irq, 1'b0);
      rst_n = 1'b1;
      cyc(1);

      for (int p = 0; p < 2; p++)
      for (int m = 0; m < 2; m++)
      for (int e = 0; e < 2; e++) begin
         logic act_lvl;
         act_lvl = (p == 1);
         cfg_enable = 1'b0;
         cfg_high_active = act_lvl; cfg_level_mode = (m == 1); cfg_irq_en = (e == 1);
         pin_async = !act_lvl;
         cyc(4);
         cfg_enable = 1'b1;
         cyc(2);
         chk("R8 idle flag", flag, 1'b0);

         // idle -> active: latency
         pin_async = act_lvl;
         cyc(2);
         chk("R2 not before third edge", flag, 1'b0);
         cyc(1);
         chk("R2 flag set", flag, 1'b1);
         chk("R7 irq", irq, (e == 1));

         // acknowledge while pin active
         pulse_ack();
         chk(m ? "R5 ack ignored" : "R4 ack clears", flag, (m == 1));
         cyc(5);
         chk(m ? "R5 held" : "R4 no reset without edge", flag, (m == 1));
         chk("R7 irq follows", irq, (m == 1) && (e == 1));

         // active -> idle
         pin_async = !act_lvl;
         cyc(4);
         chk("R3 release", flag, (m == 1));
         pulse_ack();
         chk("R5/R4 ack after release", flag, 1'b0);
         cyc(3);
         chk("R3 stays clear", flag, 1'b0);
         chk("R7 irq low", irq, 1'b0);

         // set flag, release, then ack on the same edge as a new detection
         pin_async = act_lvl;
         cyc(3);
         pin_async = !act_lvl;
         cyc(4);
         chk("R3 flag kept", flag, 1'b1);
         pin_async = act_lvl;
         cyc(2);
         pulse_ack();
         chk("R6 edge wins", flag, 1'b1);
         chk("R6 irq", irq, (e == 1));

         // disable with flag set
         cfg_enable = 1'b0;
         cyc(1);
         chk("R8 cleared", flag, 1'b0);
         chk("R8 irq", irq, 1'b0);
         pin_async = !act_lvl;
         cyc(4);
         pin_async = act_lvl;
         cyc(5);
         chk("R8 edge not recorded", flag, 1'b0);
         pin_async = !act_lvl;
         cyc(4);
      end

      for (int k = 0; k < 8; k++) begin
         cfg_enable = k[0]; cfg_pull_off = k[1]; cfg_high_active = k[2];
         cyc(1);
         chk("R9 pull_en", pull_en, k[0] && !k[1]);
         chk("R9 pull_up", pull_up, !k[2]);
      end

      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule